// File: doc/BRIEF.md
# Bit-Slice Arithmetic Logic Unit with Look-Ahead Outputs

This block is a combinational arithmetic logic unit of parameterised width, built from identical one-bit slices. A three-bit operation code picks one of eight functions. The code is the mode bit `mode` followed by the two select bits `sel[1]` and `sel[0]`. With `mode` = 0 the unit does arithmetic: transfer or increment of A, ones' or twos' complement of A, A plus B, or B minus A. With `mode` = 1 it does bitwise logic. A carry input enters the least significant slice and a carry output leaves the most significant slice, so several units can be chained by ripple.

For faster chaining, the unit also gives a group carry-propagate and a group carry-generate signal. An external look-ahead carry unit can combine these from several units and compute each unit's carry input in parallel. There are no registers. Every output follows its inputs with combinational delay only.

In the requirements, the effective A operand is A inverted for codes 001 and 011 and A itself otherwise. The effective B operand is B for codes 010 and 011 and zero otherwise. The bit `op[2:0]` means {mode, sel[1], sel[0]}. All sums are taken over WIDTH+1 bits, with the top bit being the carry.

Top module: `bslice_alu`

## Requirements
- R1: Code 000 gives {cout,res} = A + cin, which is a transfer of A when cin = 0 and an increment of A when cin = 1. B has no effect.
- R2: Code 001 gives {cout,res} = (~A) + cin, which is the ones' complement of A when cin = 0 and the twos' complement when cin = 1. B has no effect.
- R3: Code 010 gives {cout,res} = A + B + cin.
- R4: Code 011 gives {cout,res} = (~A) + B + cin. With cin = 1, res equals B minus A modulo 2^WIDTH.
- R5: The logic codes set res bitwise: code 100 gives res = A, code 101 gives res = ~A, code 110 gives res = A | B, and code 111 gives res = (~A) | B. For codes 100 and 101, B and cin have no effect.
- R6: For every logic code (mode = 1), cout, grp_p and grp_g are all 0.
- R7: In arithmetic mode, grp_g equals the carry out of (effective A + effective B) with no carry in, and cout = grp_g | (grp_p & cin).
- R8: In arithmetic mode, grp_p is 1 exactly when every bit of (effective A XOR effective B) is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opa | input | WIDTH | Operand A |
| opb | input | WIDTH | Operand B |
| mode | input | 1 | 0 = arithmetic, 1 = logic |
| sel | input | 2 | Function select within the mode |
| cin | input | 1 | Carry into the least significant slice |
| res | output | WIDTH | Result F |
| cout | output | 1 | Ripple carry out of the most significant slice |
| grp_p | output | 1 | Group carry-propagate, for look-ahead cascading |
| grp_g | output | 1 | Group carry-generate, for look-ahead cascading |

## Verification
A 4-bit instance is driven through every combination of code, A, B and carry in. This separates an error in any single slice equation from an error in how the carry travels between slices. A 16-bit instance is driven with random operands under every code. Its directed corners are an increment of all ones, the twos' complement of zero, B minus A with A greater than B, and all-propagate operands. These show whether the full-width ripple and the group propagate and generate terms agree at their extremes. For the logic codes, B and the carry in are swept while A is held. If res stays fixed and the carry and group outputs stay at 0, then the logic path does not leak.

// File: rtl/bslice_alu_pkg.sv
package bslice_alu_pkg;

  typedef enum logic [2:0] {
    OP_INC   = 3'b000,
    OP_CPL   = 3'b001,
    OP_ADD   = 3'b010,
    OP_BSUBA = 3'b011,
    OP_LA    = 3'b100,
    OP_LNA   = 3'b101,
    OP_OR    = 3'b110,
    OP_NAOR  = 3'b111
  } alu_op_e;

  typedef struct packed {
    logic       arith;
    logic       inv_a;
    logic       use_b;
    logic [1:0] lsel;
  } slice_ctl_t;

endpackage

// File: rtl/bslice_alu_dec.sv
module bslice_alu_dec
  import bslice_alu_pkg::*;
(
  input  logic       mode,
  input  logic [1:0] sel,
  output slice_ctl_t ctl
);

  alu_op_e op;

  always_comb begin
    op  = alu_op_e'({mode, sel});
    ctl = '0;
    ctl.arith = ~mode;
    ctl.lsel  = sel;
    unique case (op)
      OP_INC:   begin ctl.inv_a = 1'b0; ctl.use_b = 1'b0; end
      OP_CPL:   begin ctl.inv_a = 1'b1; ctl.use_b = 1'b0; end
      OP_ADD:   begin ctl.inv_a = 1'b0; ctl.use_b = 1'b1; end
      OP_BSUBA: begin ctl.inv_a = 1'b1; ctl.use_b = 1'b1; end
      default:  begin ctl.inv_a = 1'b0; ctl.use_b = 1'b0; end
    endcase
  end

endmodule

// File: rtl/bslice_alu_slice.sv
module bslice_alu_slice
  import bslice_alu_pkg::*;
(
  input  slice_ctl_t ctl,
  input  logic       a,
  input  logic       b,
  input  logic       ci,
  output logic       f,
  output logic       co,
  output logic       sp,
  output logic       sg
);

  logic ea;
  logic eb;
  logic half;
  logic lres;

  always_comb begin
    ea   = a ^ ctl.inv_a;
    eb   = b & ctl.use_b;
    half = ea ^ eb;
    unique case (ctl.lsel)
      2'b00:   lres = a;
      2'b01:   lres = ~a;
      2'b10:   lres = a | b;
      default: lres = ~a | b;
    endcase
    if (ctl.arith) begin
      f  = half ^ ci;
      co = (ea & eb) | (half & ci);
      sp = half;
      sg = ea & eb;
    end else begin
      f  = lres;
      co = 1'b0;
      sp = 1'b0;
      sg = 1'b0;
    end
  end

endmodule

// File: rtl/bslice_alu_la.sv
module bslice_alu_la #(
  parameter int WIDTH = 16
) (
  input  logic             arith,
  input  logic [WIDTH-1:0] sp,
  input  logic [WIDTH-1:0] sg,
  output logic             gp,
  output logic             gg
);

  logic [WIDTH-1:0] pacc;
  logic [WIDTH-1:0] gacc;

  assign pacc[0] = sp[0];
  assign gacc[0] = sg[0];

  for (genvar i = 1; i < WIDTH; i++) begin : g_chain
    assign pacc[i] = pacc[i-1] & sp[i];
    assign gacc[i] = sg[i] | (sp[i] & gacc[i-1]);
  end

  assign gp = arith & pacc[WIDTH-1];
  assign gg = arith & gacc[WIDTH-1];

endmodule

// File: rtl/bslice_alu.sv
module bslice_alu
  import bslice_alu_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] opa,
  input  logic [WIDTH-1:0] opb,
  input  logic             mode,
  input  logic [1:0]       sel,
  input  logic             cin,
  output logic [WIDTH-1:0] res,
  output logic             cout,
  output logic             grp_p,
  output logic             grp_g
);

  slice_ctl_t       ctl;
  logic [WIDTH:0]   carry;
  logic [WIDTH-1:0] sp;
  logic [WIDTH-1:0] sg;

  bslice_alu_dec u_dec (
    .mode (mode),
    .sel  (sel),
    .ctl  (ctl)
  );

  assign carry[0] = cin;

  for (genvar i = 0; i < WIDTH; i++) begin : g_slice
    bslice_alu_slice u_slice (
      .ctl (ctl),
      .a   (opa[i]),
      .b   (opb[i]),
      .ci  (carry[i]),
      .f   (res[i]),
      .co  (carry[i+1]),
      .sp  (sp[i]),
      .sg  (sg[i])
    );
  end

  assign cout = carry[WIDTH];

  bslice_alu_la #(.WIDTH(WIDTH)) u_la (
    .arith (ctl.arith),
    .sp    (sp),
    .sg    (sg),
    .gp    (grp_p),
    .gg    (grp_g)
  );

endmodule

// File: rtl/bslice_alu_chk.sv
module bslice_alu_chk #(
  parameter int WIDTH = 16
) (
  input logic [WIDTH-1:0] opa,
  input logic [WIDTH-1:0] opb,
  input logic             mode,
  input logic [1:0]       sel,
  input logic             cin,
  input logic [WIDTH-1:0] res,
  input logic             cout,
  input logic             grp_p,
  input logic             grp_g
);

  logic [WIDTH:0] inc_sum;
  logic [WIDTH:0] add_sum;
  logic [WIDTH:0] obs;

  always_comb begin
    inc_sum = {1'b0, opa} + {{WIDTH{1'b0}}, cin};
    add_sum = {1'b0, opa} + {1'b0, opb} + {{WIDTH{1'b0}}, cin};
    obs     = {cout, res};
    AST_INC_SUM: assert (!({mode, sel} == 3'b000) || obs == inc_sum)
      else $error("increment mismatch"); // R1
    AST_ADD_SUM: assert (!({mode, sel} == 3'b010) || obs == add_sum)
      else $error("add mismatch"); // R3
    AST_OR_RESULT: assert (!({mode, sel} == 3'b110) || res == (opa | opb))
      else $error("or mismatch"); // R5
    AST_LOGIC_QUIET: assert (!mode || (!cout && !grp_p && !grp_g))
      else $error("logic mode carry or group active"); // R6
    AST_LA_CARRY: assert (mode || cout == (grp_g | (grp_p & cin)))
      else $error("look-ahead carry mismatch"); // R7
  end

endmodule

bind bslice_alu bslice_alu_chk #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/bslice_alu_tb.sv
module bslice_alu_tb;

  localparam int W = 16;
  localparam int WS = 4;

  logic clk;
  logic rst_n;
  logic done;
  int   nchk;
  int   nerr;

  logic [W-1:0]  a16, b16, r16;
  logic [WS-1:0] a4, b4, r4;
  logic          mode16, cin16, co16, gp16, gg16;
  logic          mode4, cin4, co4, gp4, gg4;
  logic [1:0]    sel16, sel4;

  bslice_alu #(.WIDTH(W)) u_dut (
    .opa(a16), .opb(b16), .mode(mode16), .sel(sel16), .cin(cin16),
    .res(r16), .cout(co16), .grp_p(gp16), .grp_g(gg16)
  );

  bslice_alu #(.WIDTH(WS)) u_dut_n4 (
    .opa(a4), .opb(b4), .mode(mode4), .sel(sel4), .cin(cin4),
    .res(r4), .cout(co4), .grp_p(gp4), .grp_g(gg4)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  typedef struct packed {
    logic [16:0] sum;
    logic        p;
    logic        g;
  } exp_t;

  function automatic exp_t model(input logic [2:0] op, input logic [16:0] a,
                                 input logic [16:0] b, input logic ci, input int w);
    exp_t        e;
    logic [16:0] mask, ea, eb, t;
    mask = (17'd1 << w) - 17'd1;
    ea   = (op == 3'd1 || op == 3'd3) ? (~a & mask) : (a & mask);
    eb   = (op == 3'd2 || op == 3'd3) ? (b & mask) : 17'd0;
    e    = '0;
    if (!op[2]) begin
      t     = ea + eb + {16'd0, ci};
      e.sum = t & ((mask << 1) | 17'd1);
      e.p   = ((ea ^ eb) & mask) == mask;
      t     = ea + eb;
      e.g   = t[w];
    end else begin
      case (op[1:0])
        2'd0:    t = a;
        2'd1:    t = ~a;
        2'd2:    t = a | b;
        default: t = ~a | b;
      endcase
      e.sum = t & mask;
    end
    return e;
  endfunction

  function automatic string tag_of(input logic [2:0] op);
    case (op)
      3'd0:    return "R1";
      3'd1:    return "R2";
      3'd2:    return "R3";
      3'd3:    return "R4";
      default: return "R5";
    endcase
  endfunction

  task automatic cmp(input string req, input string what, input logic [16:0] act,
                     input logic [16:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic run16(input logic [2:0] op, input logic [W-1:0] a,
                       input logic [W-1:0] b, input logic ci);
    exp_t e;
    @(negedge clk);
    {mode16, sel16} = op;
    a16 = a; b16 = b; cin16 = ci;
    #5;
    e = model(op, {1'b0, a}, {1'b0, b}, ci, W);
    if (!op[2]) cmp(tag_of(op), "cout,res", {co16, r16}, e.sum);
    else        cmp("R5", "res", {1'b0, r16}, e.sum);
    cmp(op[2] ? "R6" : "R8", "grp_p", {16'd0, gp16}, {16'd0, e.p});
    cmp(op[2] ? "R6" : "R7", "grp_g", {16'd0, gg16}, {16'd0, e.g});
    if (op[2]) cmp("R6", "cout", {16'd0, co16}, 17'd0);
    else cmp("R7", "cout=G|P&cin", {16'd0, co16}, {16'd0, gg16 | (gp16 & ci)});
  endtask

  task automatic t_idle;
    @(negedge clk);
    {mode16, sel16} = 3'd0; a16 = '0; b16 = '0; cin16 = 1'b0;
    #5;
    cmp("R1", "idle res", {co16, r16}, 17'd0);
  endtask

  task automatic t_exhaustive4;
    exp_t e;
    for (int op = 0; op < 8; op++)
      for (int a = 0; a < 16; a++)
        for (int b = 0; b < 16; b++)
          for (int c = 0; c < 2; c++) begin
            {mode4, sel4} = 3'(op);
            a4 = 4'(a); b4 = 4'(b); cin4 = 1'(c);
            #1;
            e = model(3'(op), 17'(a), 17'(b), 1'(c), WS);
            if (op < 4) cmp(tag_of(3'(op)), "n4 cout,res", {12'd0, co4, r4}, e.sum);
            else begin
              cmp("R5", "n4 res", {13'd0, r4}, e.sum);
              cmp("R6", "n4 cout", {16'd0, co4}, 17'd0);
            end
            cmp(op < 4 ? "R8" : "R6", "n4 grp_p", {16'd0, gp4}, {16'd0, e.p});
            cmp(op < 4 ? "R7" : "R6", "n4 grp_g", {16'd0, gg4}, {16'd0, e.g});
          end
  endtask

  task automatic t_random16;
    for (int op = 0; op < 8; op++)
      for (int k = 0; k < 150; k++)
        run16(3'(op), 16'($urandom), 16'($urandom), 1'($urandom));
  endtask

  task automatic t_corners;
    run16(3'd0, 16'hFFFF, 16'h1234, 1'b1);  // R1 increment wraps
    cmp("R1", "inc wrap", {co16, r16}, 17'h10000);
    run16(3'd1, 16'h0000, 16'hABCD, 1'b1);  // R2 twos complement of zero
    cmp("R2", "neg zero", {co16, r16}, 17'h10000);
    run16(3'd1, 16'h0005, 16'h0000, 1'b1);
    cmp("R2", "neg five", {1'b0, r16}, 17'h0FFFB);
    run16(3'd3, 16'h0007, 16'h0005, 1'b1);  // R4 B-A negative
    cmp("R4", "5-7", {1'b0, r16}, 17'h0FFFE);
    run16(3'd3, 16'h0003, 16'h0009, 1'b1);
    cmp("R4", "9-3", {1'b0, r16}, 17'h00006);
    run16(3'd2, 16'hAAAA, 16'h5555, 1'b1);  // R8 all propagate
    cmp("R8", "all prop", {16'd0, gp16}, 17'd1);
    cmp("R7", "all prop carry", {co16, r16}, 17'h10000);
    run16(3'd2, 16'h8000, 16'h8000, 1'b0);  // R7 generate at top
    cmp("R7", "gen top", {16'd0, gg16}, 17'd1);
  endtask

  task automatic t_logic_ignores;
    for (int k = 0; k < 8; k++) begin
      run16(3'd4, 16'h3C5A, 16'($urandom), 1'($urandom));
      cmp("R5", "pass A ignores B,cin", {1'b0, r16}, 17'h03C5A);
      run16(3'd5, 16'h3C5A, 16'($urandom), 1'($urandom));
      cmp("R5", "not A ignores B,cin", {1'b0, r16}, 17'h0C3A5);
      run16(3'd0, 16'h3C5A, 16'($urandom), 1'b0);
      cmp("R1", "transfer ignores B", {co16, r16}, 17'h03C5A);
      run16(3'd1, 16'h3C5A, 16'($urandom), 1'b0);
      cmp("R2", "cpl ignores B", {co16, r16}, 17'h0C3A5);
    end
  endtask

  initial begin
    done = 1'b0;
    #(20 * 200000);
    if (!done) begin
      nerr++;
      nchk++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    nchk = 0; nerr = 0;
    rst_n = 1'b0;
    a16 = '0; b16 = '0; mode16 = 1'b0; sel16 = '0; cin16 = 1'b0;
    a4 = '0; b4 = '0; mode4 = 1'b0; sel4 = '0; cin4 = 1'b0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    t_idle();
    t_exhaustive4();
    t_random16();
    t_corners();
    t_logic_ignores();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

endmodule